// File: doc/BRIEF.md
# IN Endpoint Transfer Size Tracker

This block keeps the transfer bookkeeping for one device-side USB IN endpoint. Software loads a byte count, a packet count and a packets-per-frame value into one 32-bit register while the endpoint is idle, then arms the endpoint. From that point the hardware owns the register. Each packet copied from memory into the transmit FIFO takes its byte length off the byte count. Each packet drained from the FIFO onto the bus takes one off the packet count.

When both counts are zero the block disarms the endpoint and raises a one-cycle completion interrupt. It also tracks the data PID for high-bandwidth isochronous traffic. At each frame start the PID is set from the packets-per-frame value, and it steps down toward DATA0 as packets drain. A FIFO fill that is longer than the remaining byte count clamps the count at zero and sets a sticky error flag. Software can abort an armed endpoint without getting an interrupt.

Top module: `ep_in_xfer_tracker`

## Requirements
- R1: After reset, `reg_rdata`, `ep_enabled`, `xfer_done_irq`, `len_err` and `pid_out` are all zero.
- R2: While the endpoint is idle, `reg_wr` loads the register. The next cycle `reg_rdata` reads back bit 31 as 0, the packets-per-frame field at bits 30:29, the packet count at bits 28:19 and the byte count at bits 18:0.
- R3: While `ep_enabled` is high, `reg_wr` has no effect on `reg_rdata`.
- R4: `enable_set` while idle drives `ep_enabled` high on the next cycle. `rd_unstable` equals `ep_enabled`, and `enable_set` while armed has no effect.
- R5: While armed, `fifo_wr` with length L not above the byte count lowers the byte count by L on the next cycle. `fifo_wr` is ignored while idle.
- R6: While armed, `fifo_rd` lowers a nonzero packet count by one on the next cycle. `fifo_rd` is ignored while idle.
- R7: A `fifo_wr` while armed with L above the byte count sets the byte count to 0 and sets `len_err`. `len_err` stays set until the next `enable_set` that arms the endpoint, which clears it.
- R8: When the endpoint is armed and both counts are zero, the next cycle has `ep_enabled` low and `xfer_done_irq` high for exactly one cycle.
- R9: `pid_out` encodes 0 = DATA0, 1 = DATA1, 2 = DATA2. `frame_start`, or an arming `enable_set`, loads it with packets-per-frame minus one (value 00 counts as one packet). Each armed `fifo_rd` then lowers it by one, stopping at DATA0.
- R10: An armed `fifo_rd` with the packet count at zero leaves it at zero.
- R11: `ep_disable` while armed drives `ep_enabled` low on the next cycle without raising `xfer_done_irq`, and leaves the counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value (live) |
| rd_unstable | output | 1 | Read value still being updated by hardware |
| enable_set | input | 1 | Arm the endpoint |
| ep_disable | input | 1 | Abort an armed endpoint |
| ep_enabled | output | 1 | Endpoint armed |
| fifo_wr | input | 1 | Packet written into transmit FIFO |
| fifo_wr_len | input | 11 | Byte length of that packet |
| fifo_rd | input | 1 | Packet read out of transmit FIFO |
| frame_start | input | 1 | New frame for PID sequencing |
| pid_out | output | 2 | Data PID for the next drained packet |
| xfer_done_irq | output | 1 | Completion pulse |
| len_err | output | 1 | Sticky fill-length overrun flag |

## Verification
Every result is registered once, so each effect of a stimulus shows at the ports one clock after the edge that samples it. The completion pulse is the exception: it appears one clock after the edge where both counts are already zero, which is two clocks after the last counter decrement. The bench drives inputs just after a falling edge. A reference model is updated at the rising edge, and all outputs are compared at the next falling edge, so each check falls on the cycle the requirement names. A directed pass sets up the completion, overrun, saturation, abort and PID cases. A seeded random run then compares every output on every cycle.

// File: rtl/ep_tsz_pkg.sv
package ep_tsz_pkg;
    localparam int REG_W  = 32;
    localparam int SIZE_W = 19;
    localparam int PKT_W  = 10;
    localparam int MC_W   = 2;
    localparam int LEN_W  = 11;

    typedef enum logic [1:0] {
        PID_DATA0 = 2'd0,
        PID_DATA1 = 2'd1,
        PID_DATA2 = 2'd2
    } pid_e;

    // packets-per-frame -> PID of the first packet in a frame
    function automatic pid_e first_pid(input logic [MC_W-1:0] mc);
        case (mc)
            2'd3:    return PID_DATA2;
            2'd2:    return PID_DATA1;
            default: return PID_DATA0;
        endcase
    endfunction
endpackage

// File: rtl/ep_byte_cnt.sv
module ep_byte_cnt #(
    parameter int SIZE_W = 19,
    parameter int LEN_W  = 11
) (
    input  logic [SIZE_W-1:0] cur,
    input  logic              load,
    input  logic [SIZE_W-1:0] load_val,
    input  logic              dec,
    input  logic [LEN_W-1:0]  len,
    output logic [SIZE_W-1:0] nxt,
    output logic              ovf
);
    localparam int CMP_W = (SIZE_W > LEN_W) ? SIZE_W : LEN_W;

    logic [CMP_W-1:0] cur_w, len_w;

    always_comb begin
        cur_w = CMP_W'(cur);
        len_w = CMP_W'(len);
        ovf   = 1'b0;
        nxt   = cur;
        if (load) begin
            nxt = load_val;
        end else if (dec) begin
            if (len_w > cur_w) begin
                nxt = '0;
                ovf = 1'b1;
            end else begin
                nxt = SIZE_W'(cur_w - len_w);
            end
        end
    end
endmodule

// File: rtl/ep_pkt_cnt.sv
module ep_pkt_cnt #(
    parameter int PKT_W = 10
) (
    input  logic [PKT_W-1:0] cur,
    input  logic             load,
    input  logic [PKT_W-1:0] load_val,
    input  logic             dec,
    output logic [PKT_W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (load)
            nxt = load_val;
        else if (dec && cur != '0)
            nxt = cur - PKT_W'(1);
    end
endmodule

// File: rtl/ep_pid_seq.sv
module ep_pid_seq
    import ep_tsz_pkg::*;
(
    input  pid_e            cur,
    input  logic            reload,
    input  logic [MC_W-1:0] mc,
    input  logic            step,
    output pid_e            nxt
);
    always_comb begin
        nxt = cur;
        if (reload)
            nxt = first_pid(mc);
        else if (step && cur != PID_DATA0)
            nxt = pid_e'(cur - 2'd1);
    end
endmodule

// File: rtl/ep_in_xfer_tracker.sv
module ep_in_xfer_tracker
    import ep_tsz_pkg::*;
#(
    parameter int SZ_W  = SIZE_W,
    parameter int PC_W  = PKT_W,
    parameter int BL_W  = LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             rd_unstable,
    input  logic             enable_set,
    input  logic             ep_disable,
    output logic             ep_enabled,
    input  logic             fifo_wr,
    input  logic [BL_W-1:0]  fifo_wr_len,
    input  logic             fifo_rd,
    input  logic             frame_start,
    output logic [1:0]       pid_out,
    output logic             xfer_done_irq,
    output logic             len_err
);
    localparam int PC_LSB = SZ_W;
    localparam int MC_LSB = SZ_W + PC_W;

    typedef struct packed {
        logic            en;
        logic            irq;
        logic            err;
        logic [MC_W-1:0] mc;
        logic [PC_W-1:0] pkt;
        logic [SZ_W-1:0] size;
        pid_e            pid;
    } state_t;

    state_t st_q, st_d;

    logic            wr_ok, arm, fill, drain, done, ovf;
    logic [MC_W-1:0] mc_n;
    logic [SZ_W-1:0] size_n;
    logic [PC_W-1:0] pkt_n;
    pid_e            pid_n;

    assign wr_ok = reg_wr & ~st_q.en;
    assign arm   = enable_set & ~st_q.en;
    assign fill  = fifo_wr & st_q.en;
    assign drain = fifo_rd & st_q.en;
    assign done  = st_q.en & (st_q.size == '0) & (st_q.pkt == '0);
    assign mc_n  = wr_ok ? reg_wdata[MC_LSB +: MC_W] : st_q.mc;

    ep_byte_cnt #(.SIZE_W(SZ_W), .LEN_W(BL_W)) u_bytes (
        .cur(st_q.size), .load(wr_ok), .load_val(reg_wdata[0 +: SZ_W]),
        .dec(fill), .len(fifo_wr_len), .nxt(size_n), .ovf(ovf)
    );

    ep_pkt_cnt #(.PKT_W(PC_W)) u_pkts (
        .cur(st_q.pkt), .load(wr_ok), .load_val(reg_wdata[PC_LSB +: PC_W]),
        .dec(drain), .nxt(pkt_n)
    );

    ep_pid_seq u_pid (
        .cur(st_q.pid), .reload(frame_start | arm), .mc(mc_n),
        .step(drain), .nxt(pid_n)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mc   = mc_n;
        st_d.size = size_n;
        st_d.pkt  = pkt_n;
        st_d.pid  = pid_n;
        st_d.irq  = done;
        if (arm)
            st_d.err = 1'b0;
        else if (ovf)
            st_d.err = 1'b1;
        if (arm)
            st_d.en = 1'b1;
        else if (st_q.en && (ep_disable || done))
            st_d.en = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign reg_rdata     = REG_W'({st_q.mc, st_q.pkt, st_q.size});
    assign rd_unstable   = st_q.en;
    assign ep_enabled    = st_q.en;
    assign pid_out       = st_q.pid;
    assign xfer_done_irq = st_q.irq;
    assign len_err       = st_q.err;
endmodule

// File: rtl/ep_in_xfer_tracker_chk.sv
module ep_in_xfer_tracker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic        enable_set,
    input logic        ep_enabled,
    input logic        fifo_wr,
    input logic        fifo_rd,
    input logic [1:0]  pid_out,
    input logic        xfer_done_irq,
    input logic        len_err
);
    p_irq_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_irq |=> !xfer_done_irq);

    p_irq_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_irq |-> !ep_enabled);

    p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_enabled && !fifo_wr && !fifo_rd) |=> $stable(reg_rdata));

    p_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ep_enabled && enable_set) |=> ep_enabled);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (len_err && !(enable_set && !ep_enabled)) |=> len_err);

    p_pid_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pid_out != 2'b11);

    p_pkt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_enabled && fifo_rd && reg_rdata[28:19] != 10'd0)
        |=> reg_rdata[28:19] == $past(reg_rdata[28:19]) - 10'd1);

    p_bit31_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31] == 1'b0);
endmodule

bind ep_in_xfer_tracker ep_in_xfer_tracker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .enable_set(enable_set),
    .ep_enabled(ep_enabled), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
    .pid_out(pid_out), .xfer_done_irq(xfer_done_irq), .len_err(len_err)
);

// File: tb/ep_in_xfer_tracker_bench.sv
module ep_in_xfer_tracker_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_unstable;
    logic        enable_set = 1'b0;
    logic        ep_disable = 1'b0;
    logic        ep_enabled;
    logic        fifo_wr = 1'b0;
    logic [10:0] fifo_wr_len = '0;
    logic        fifo_rd = 1'b0;
    logic        frame_start = 1'b0;
    logic [1:0]  pid_out;
    logic        xfer_done_irq;
    logic        len_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference model
    logic [1:0]  m_mc;
    logic [9:0]  m_pkt;
    logic [18:0] m_size;
    logic        m_en, m_err, m_irq;
    logic [1:0]  m_pid;

    always #(CLK_PERIOD/2) clk = ~clk;

    ep_in_xfer_tracker u_ep_in_xfer_tracker (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rd_unstable(rd_unstable), .enable_set(enable_set),
        .ep_disable(ep_disable), .ep_enabled(ep_enabled), .fifo_wr(fifo_wr),
        .fifo_wr_len(fifo_wr_len), .fifo_rd(fifo_rd), .frame_start(frame_start),
        .pid_out(pid_out), .xfer_done_irq(xfer_done_irq), .len_err(len_err)
    );

    function automatic logic [1:0] first_of(input logic [1:0] mc);
        return (mc == 2'd3) ? 2'd2 : (mc == 2'd2) ? 2'd1 : 2'd0;
    endfunction

    function automatic logic [31:0] pack(input logic [1:0] mc, input logic [9:0] pk,
                                         input logic [18:0] sz);
        return {1'b0, mc, pk, sz};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic        go;
        logic [1:0]  mc_n;
        go = enable_set && !m_en;
        mc_n = m_mc;
        if (reg_wr && !m_en) begin
            mc_n   = reg_wdata[30:29];
            m_pkt  = reg_wdata[28:19];
            m_size = reg_wdata[18:0];
        end
        if (frame_start || go)
            m_pid = first_of(mc_n);
        else if (m_en && fifo_rd && m_pid != 2'd0)
            m_pid = m_pid - 2'd1;
        m_irq = m_en && m_size == 0 && m_pkt == 0;
        if (m_en && fifo_wr) begin
            if (32'(fifo_wr_len) > 32'(m_size)) begin
                m_size = '0;
                m_err  = 1'b1;
            end else begin
                m_size = m_size - 19'(fifo_wr_len);
            end
        end
        if (m_en && fifo_rd && m_pkt != 0)
            m_pkt = m_pkt - 10'd1;
        m_mc = mc_n;
        if (go) begin
            m_en  = 1'b1;
            m_err = 1'b0;
        end else if (m_en && (ep_disable || m_irq)) begin
            m_en = 1'b0;
        end
    endtask

    task automatic compare_all();
        check("R2/R3/R5/R6/R10 rdata", reg_rdata, pack(m_mc, m_pkt, m_size));
        check("R4/R8/R11 enabled", 32'(ep_enabled), 32'(m_en));
        check("R4 unstable", 32'(rd_unstable), 32'(m_en));
        check("R8 irq", 32'(xfer_done_irq), 32'(m_irq));
        check("R7 err", 32'(len_err), 32'(m_err));
        check("R9 pid", 32'(pid_out), 32'(m_pid));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        reg_wr = 0; enable_set = 0; ep_disable = 0; fifo_wr = 0;
        fifo_rd = 0; frame_start = 0; fifo_wr_len = '0;
    endtask

    task automatic do_write(input logic [31:0] v);
        reg_wr = 1; reg_wdata = v; step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_mc = 0; m_pkt = 0; m_size = 0; m_en = 0; m_err = 0; m_irq = 0; m_pid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 enabled", 32'(ep_enabled), 32'h0);
        check("R1 irq", 32'(xfer_done_irq), 32'h0);
        check("R1 err", 32'(len_err), 32'h0);
        check("R1 pid", 32'(pid_out), 32'h0);

        // R2 layout
        do_write(32'hFFFF_FFFF);
        check("R2 bit31 zero", reg_rdata, 32'h7FFF_FFFF);
        do_write(pack(2'd3, 10'd2, 19'd100));
        check("R2 fields", reg_rdata, 32'h6010_0064);
        // R4 arm, R9 first PID for three per frame
        enable_set = 1; step();
        check("R4 armed", 32'(ep_enabled), 32'h1);
        check("R9 DATA2 first", 32'(pid_out), 32'h2);
        // R3 write ignored
        do_write(pack(2'd1, 10'd7, 19'd7));
        check("R3 write ignored", reg_rdata, pack(2'd3, 10'd2, 19'd100));
        // R5, R6, R9 stepping
        fifo_wr = 1; fifo_wr_len = 11'd60; step();
        check("R5 size minus len", 32'(reg_rdata[18:0]), 32'd40);
        fifo_rd = 1; step();
        check("R6 pkt minus one", 32'(reg_rdata[28:19]), 32'd1);
        check("R9 DATA1 next", 32'(pid_out), 32'h1);
        fifo_wr = 1; fifo_wr_len = 11'd40; step();
        fifo_rd = 1; step();
        check("R9 DATA0 last", 32'(pid_out), 32'h0);
        check("R8 not yet", 32'(xfer_done_irq), 32'h0);
        step();
        check("R8 irq pulse", 32'(xfer_done_irq), 32'h1);
        check("R8 disarmed", 32'(ep_enabled), 32'h0);
        step();
        check("R8 single cycle", 32'(xfer_done_irq), 32'h0);

        // R7 overrun, R9 mc=0 as one packet
        do_write(pack(2'd0, 10'd1, 19'd10));
        enable_set = 1; step();
        check("R9 mc0 DATA0", 32'(pid_out), 32'h0);
        fifo_wr = 1; fifo_wr_len = 11'd30; step();
        check("R7 size clamped", 32'(reg_rdata[18:0]), 32'd0);
        check("R7 err set", 32'(len_err), 32'h1);
        fifo_rd = 1; step();
        step(); step();
        check("R7 err sticky", 32'(len_err), 32'h1);

        // R10 saturation, R11 abort
        do_write(pack(2'd2, 10'd0, 19'd50));
        enable_set = 1; step();
        check("R7 err cleared on arm", 32'(len_err), 32'h0);
        check("R9 DATA1 first", 32'(pid_out), 32'h1);
        fifo_rd = 1; step();
        check("R10 pkt stays zero", 32'(reg_rdata[28:19]), 32'd0);
        frame_start = 1; step();
        check("R9 frame reload", 32'(pid_out), 32'h1);
        ep_disable = 1; step();
        check("R11 disarmed", 32'(ep_enabled), 32'h0);
        check("R11 no irq", 32'(xfer_done_irq), 32'h0);
        check("R11 counts kept", reg_rdata, pack(2'd2, 10'd0, 19'd50));
        fifo_wr = 1; fifo_wr_len = 11'd5; fifo_rd = 1; step();
        check("R5/R6 ignored idle", reg_rdata, pack(2'd2, 10'd0, 19'd50));

        // seeded random run against the model
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 10) begin
                reg_wr = 1;
                reg_wdata = {$urandom()} & 32'hFFFF_FFFF;
                reg_wdata[28:19] = 10'($urandom_range(0, 6));
                reg_wdata[18:0]  = 19'($urandom_range(0, 300));
            end
            enable_set  = ($urandom_range(0, 99) < 15);
            ep_disable  = ($urandom_range(0, 99) < 2);
            fifo_wr     = ($urandom_range(0, 99) < 35);
            fifo_wr_len = 11'($urandom_range(0, 80));
            fifo_rd     = ($urandom_range(0, 99) < 30);
            frame_start = ($urandom_range(0, 99) < 8);
            step();
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule